// File: doc/BRIEF.md
# Indirect PHY Register Access Bridge

This block lets a host on a 32-bit register bus reach the registers of an internal gigabit PHY without a direct path to its management port. The host loads a data register with an operation bit, a 7-bit PHY register index and, for writes, 16 bits of data. It then writes a fixed command word to a command/flag register and polls bit 31 of that register until the operation is reported complete.

A PHY write is one command, and its flag reads 1 while busy and 0 when done. A PHY read is two commands. The first, with the operation bit clear, only latches the register index. The second starts the read fetch, which drives the flag to 0 while busy and to 1 once the returned value sits in the low half of the data register.

On the PHY side, the bridge holds a request with direction, index and write data until a one-cycle acknowledge arrives. The acknowledge carries read data. A bounded timeout keeps any operation from hanging the host's poll loop. A small receive-error counter shares the bus and is cleared by any write to its offset.

Top module: `phy_reg_bridge`

## Requirements
- R1: After reset, the data register, the flag bit (bit 31 at offset 0xB4) and the error counter (offset 0x7C) all read 0, and no PHY request is raised.
- R2: A write to offset 0xB0 stores all 32 bits, which read back unchanged on the next cycle. Reads from an unmapped offset return 0.
- R3: A command write of 0x8000F060 at 0xB4 while idle, with data bit 31 = 1, raises a PHY write request on the next cycle. The request carries index = data[22:16] and wdata = data[15:0]. The flag reads 1 until the acknowledge and reads 0 the cycle after it.
- R4: The same command with data bit 31 = 0 latches data[22:16] as the read index and raises no PHY request. The flag reads 1 for exactly one cycle, then 0.
- R5: A command write of 0x0000F060 while idle drives the flag to 0 and raises a PHY read request for the latched index. On the acknowledge, data[15:0] takes the returned value, data[31:16] is kept, and the flag reads 1 the next cycle.
- R6: Command writes that arrive while an operation is in progress are ignored. They start no PHY transaction and do not alter the flag.
- R7: A command write whose bits 30:0 differ from 0x0000F060 is ignored while idle. The flag keeps its value and no PHY request is raised.
- R8: Each rx_err pulse increments the counter at 0x7C, which saturates at its maximum. Any write to 0x7C clears it, so it reads 0 on the next cycle.
- R9: If no acknowledge arrives within TIMEOUT cycles of the request, the request is dropped and the flag takes its completion value. A timed-out read fetch leaves 0xFFFF in data[15:0].
- R10: While a request waits for its acknowledge, its direction, index and write data stay constant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Host write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Host byte offset for reads and writes |
| bus_wdata | input | 32 | Host write data |
| bus_rdata | output | 32 | Host read data for bus_addr, combinational |
| rx_err | input | 1 | Receive-error event pulse |
| mgmt_req | output | 1 | PHY management request, held until acknowledge or timeout |
| mgmt_wr | output | 1 | Request direction, 1 = write |
| mgmt_idx | output | 7 | PHY register index |
| mgmt_wdata | output | 16 | PHY write data |
| mgmt_ack | input | 1 | One-cycle acknowledge from the PHY |
| mgmt_rdata | input | 16 | PHY read data, valid with mgmt_ack |

## Verification
Register writes and counter clears show up on the read port one cycle after the write edge. The address-latch phase keeps the flag at 1 for exactly one cycle. When the PHY model acknowledges L cycles after it first sees the request, a write or read fetch changes the flag L+1 cycles after the command is taken, and a silent PHY gives TIMEOUT cycles instead. The bench drives and samples on the falling edge and counts falling edges from the command's capture edge to the flag change, so each sweep step compares that count with the latency it chose, for latencies 0 to 3 across all 128 register indices.

// File: rtl/phy_reg_bridge.sv
module phy_reg_bridge #(
  parameter int ADDR_W  = 8,
  parameter int TIMEOUT = 4096,
  parameter int ERR_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              rx_err,
  output logic              mgmt_req,
  output logic              mgmt_wr,
  output logic [6:0]        mgmt_idx,
  output logic [15:0]       mgmt_wdata,
  input  logic              mgmt_ack,
  input  logic [15:0]       mgmt_rdata
);

  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'('hB0);
  localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'('hB4);
  localparam logic [ADDR_W-1:0] A_ERR  = ADDR_W'('h7C);
  localparam logic [30:0]       KEY    = 31'h0000F060;
  localparam int                TMO_W  = $clog2(TIMEOUT + 1);

  typedef enum logic [1:0] {S_IDLE, S_ADR, S_REQ} state_t;

  state_t            state;
  logic [31:0]       data_q;
  logic [6:0]        idx_q;
  logic [15:0]       wdata_q;
  logic              wr_q;
  logic              flag_q;
  logic [TMO_W-1:0]  tmo_cnt;
  logic [ERR_W-1:0]  err_q;

  wire wr_data = bus_wr && bus_addr == A_DATA;
  wire wr_cmd  = bus_wr && bus_addr == A_CMD;
  wire wr_err  = bus_wr && bus_addr == A_ERR;
  wire cmd_ok  = wr_cmd && state == S_IDLE && bus_wdata[30:0] == KEY;
  wire tmo_hit = state == S_REQ && !mgmt_ack && tmo_cnt == TMO_W'(TIMEOUT - 1);
  wire done    = state == S_REQ && (mgmt_ack || tmo_hit);
  wire [15:0] ret = mgmt_ack ? mgmt_rdata : 16'hFFFF;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      idx_q   <= '0;
      wdata_q <= '0;
      wr_q    <= 1'b0;
      flag_q  <= 1'b0;
      tmo_cnt <= '0;
    end else begin
      case (state)
        S_IDLE: if (cmd_ok) begin
          tmo_cnt <= '0;
          if (bus_wdata[31]) begin
            idx_q  <= data_q[22:16];
            flag_q <= 1'b1;
            if (data_q[31]) begin
              state   <= S_REQ;
              wr_q    <= 1'b1;
              wdata_q <= data_q[15:0];
            end else begin
              state <= S_ADR;
            end
          end else begin
            state  <= S_REQ;
            wr_q   <= 1'b0;
            flag_q <= 1'b0;
          end
        end
        S_ADR: begin
          state  <= S_IDLE;
          flag_q <= 1'b0;
        end
        S_REQ: begin
          tmo_cnt <= tmo_cnt + 1'b1;
          if (done) begin
            state   <= S_IDLE;
            flag_q  <= !wr_q;
            tmo_cnt <= '0;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) data_q <= '0;
    else begin
      if (wr_data) data_q <= bus_wdata;
      if (done && !wr_q) data_q[15:0] <= ret;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= '0;
    else if (wr_err) err_q <= '0;
    else if (rx_err && !(&err_q)) err_q <= err_q + 1'b1;
  end

  assign mgmt_req   = state == S_REQ;
  assign mgmt_wr    = wr_q;
  assign mgmt_idx   = idx_q;
  assign mgmt_wdata = wdata_q;

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == A_DATA)     bus_rdata = data_q;
    else if (bus_addr == A_CMD) bus_rdata = {flag_q, 31'd0};
    else if (bus_addr == A_ERR) bus_rdata = 32'(err_q);
  end

  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mgmt_req && !mgmt_ack && !tmo_hit) |=>
      (mgmt_req && $stable(mgmt_wr) && $stable(mgmt_idx) && $stable(mgmt_wdata)));

  p_wr_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mgmt_req && mgmt_ack && mgmt_wr) |=> (!flag_q && !mgmt_req));

  p_fetch_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mgmt_req && mgmt_ack && !mgmt_wr) |=>
      (flag_q && data_q[15:0] == $past(mgmt_rdata)));

  p_adr_phase_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_ADR) |=> (!flag_q && !mgmt_req));

  p_bad_cmd_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && wr_cmd && bus_wdata[30:0] != KEY) |=>
      ($stable(flag_q) && !mgmt_req));

  p_busy_ignore_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mgmt_req && !done && wr_cmd) |=> (mgmt_req && $stable(mgmt_wr) && $stable(flag_q)));

  p_err_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err |=> (err_q == '0));

  p_tmo_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_hit && !mgmt_wr) |=> (!mgmt_req && flag_q && data_q[15:0] == 16'hFFFF));

endmodule

// File: tb/sim_phy_reg_bridge.sv
module sim_phy_reg_bridge;
  localparam int TMO = 64;

  logic clk = 0, rst_n = 0;
  logic bus_wr = 0;
  logic [7:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic rx_err = 0;
  logic mgmt_req, mgmt_wr, mgmt_ack = 0;
  logic [6:0] mgmt_idx;
  logic [15:0] mgmt_wdata, mgmt_rdata = 0;

  phy_reg_bridge #(.ADDR_W(8), .TIMEOUT(TMO), .ERR_W(4)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_err(rx_err),
    .mgmt_req(mgmt_req), .mgmt_wr(mgmt_wr), .mgmt_idx(mgmt_idx),
    .mgmt_wdata(mgmt_wdata), .mgmt_ack(mgmt_ack), .mgmt_rdata(mgmt_rdata));

  always #5 clk = ~clk;

  int nvec = 0, nbad = 0;
  bit finished = 0;

  logic [15:0] mem [128];
  int lat = 0, cnt = 0, txn = 0, stab_err = 0;
  bit noack = 0;
  logic f_wr; logic [6:0] f_idx; logic [15:0] f_wd;
  logic l_wr; logic [6:0] l_idx; logic [15:0] l_wd;

  always @(negedge clk) begin
    if (mgmt_ack) begin
      mgmt_ack = 0;
    end else if (mgmt_req) begin
      if (cnt == 0) begin f_wr = mgmt_wr; f_idx = mgmt_idx; f_wd = mgmt_wdata; end
      else if (f_wr != mgmt_wr || f_idx != mgmt_idx || f_wd != mgmt_wdata) stab_err++;
      if (!noack && cnt >= lat) begin
        mgmt_ack = 1;
        mgmt_rdata = mem[mgmt_idx];
        if (mgmt_wr) mem[mgmt_idx] = mgmt_wdata;
        l_wr = mgmt_wr; l_idx = mgmt_idx; l_wd = mgmt_wdata;
        txn++;
        cnt = 0;
      end else cnt++;
    end else cnt = 0;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic poll(input logic want, output int cyc);
    logic [31:0] v;
    cyc = 0;
    forever begin
      rd(8'hB4, v);
      if (v[31] == want || cyc > 200) break;
      @(negedge clk);
      cyc++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nbad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int cyc, t0;
    for (int i = 0; i < 128; i++) mem[i] = 16'h0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    rd(8'hB0, v); chk("R1 data", v, 0);
    rd(8'hB4, v); chk("R1 flag", v, 0);
    rd(8'h7C, v); chk("R1 errcnt", v, 0);
    chk("R1 req", 32'(mgmt_req), 0);

    wr(8'hB0, 32'hDEAD_BEEF);
    rd(8'hB0, v); chk("R2 readback", v, 32'hDEAD_BEEF);
    rd(8'h40, v); chk("R2 unmapped", v, 0);

    for (int i = 0; i < 128; i++) begin
      logic [15:0] val = 16'(i * 40503 + 1234);
      lat = i % 4;
      wr(8'hB0, {1'b1, 8'h00, 7'(i), val});
      wr(8'hB4, 32'h8000F060);
      rd(8'hB4, v); chk("R3 busy flag", 32'(v[31]), 1);
      poll(1'b0, cyc);
      chk("R3 write latency", cyc, lat + 1);
      chk("R3 req fields", {15'd0, l_wr, l_idx, l_wd}, {15'd0, 1'b1, 7'(i), val});
    end

    for (int i = 0; i < 128; i++) begin
      logic [15:0] val = 16'(i * 40503 + 1234);
      lat = (i + 1) % 4;
      t0 = txn;
      wr(8'hB0, {1'b0, 8'h3C, 7'(i), 16'h1357});
      wr(8'hB4, 32'h8000F060);
      rd(8'hB4, v); chk("R4 adr flag", 32'(v[31]), 1);
      poll(1'b0, cyc);
      chk("R4 adr one cycle", cyc, 1);
      chk("R4 no txn", txn, t0);
      wr(8'hB4, 32'h0000F060);
      rd(8'hB4, v); chk("R5 busy flag", 32'(v[31]), 0);
      poll(1'b1, cyc);
      chk("R5 fetch latency", cyc, lat + 1);
      rd(8'hB0, v); chk("R5 fetch data", v, {1'b0, 8'h3C, 7'(i), val});
      chk("R5 rd dir", {24'd0, l_wr, l_idx}, {24'd0, 1'b0, 7'(i)});
    end

    lat = 6;
    t0 = txn;
    wr(8'hB0, {1'b1, 8'h00, 7'd5, 16'h1111});
    wr(8'hB4, 32'h8000F060);
    wr(8'hB4, 32'h0000F060);
    wr(8'hB4, 32'h8000F060);
    rd(8'hB4, v); chk("R6 flag while busy", 32'(v[31]), 1);
    poll(1'b0, cyc);
    repeat (10) @(negedge clk);
    rd(8'hB4, v); chk("R6 flag after", 32'(v[31]), 0);
    chk("R6 one txn", txn, t0 + 1);
    chk("R6 mem", 32'(mem[5]), 32'h1111);

    lat = 0;
    t0 = txn;
    wr(8'hB4, 32'h8000F061);
    repeat (4) @(negedge clk);
    rd(8'hB4, v); chk("R7 flag stays 0", 32'(v[31]), 0);
    chk("R7 no txn", txn, t0);
    wr(8'hB0, {1'b0, 8'h00, 7'd5, 16'h0});
    wr(8'hB4, 32'h8000F060); poll(1'b0, cyc);
    wr(8'hB4, 32'h0000F060); poll(1'b1, cyc);
    rd(8'hB0, v); chk("R5 reread", v, {1'b0, 8'h00, 7'd5, 16'h1111});
    t0 = txn;
    wr(8'hB4, 32'h0000F000);
    repeat (4) @(negedge clk);
    rd(8'hB4, v); chk("R7 flag stays 1", 32'(v[31]), 1);
    chk("R7 no txn 2", txn, t0);

    for (int k = 0; k < 5; k++) begin rx_err = 1; @(negedge clk); rx_err = 0; @(negedge clk); end
    rd(8'h7C, v); chk("R8 count", v, 5);
    wr(8'h7C, 32'hFFFF_FFFF);
    rd(8'h7C, v); chk("R8 cleared", v, 0);
    rx_err = 1; repeat (20) @(negedge clk); rx_err = 0;
    rd(8'h7C, v); chk("R8 saturate", v, 15);
    wr(8'h7C, 0);
    rd(8'h7C, v); chk("R8 cleared 2", v, 0);

    noack = 1;
    wr(8'hB4, 32'h0000F060);
    poll(1'b1, cyc);
    chk("R9 read timeout cycles", cyc, TMO);
    rd(8'hB0, v); chk("R9 read timeout data", v, {1'b0, 8'h00, 7'd5, 16'hFFFF});
    chk("R9 req dropped", 32'(mgmt_req), 0);
    wr(8'hB0, {1'b1, 8'h00, 7'd9, 16'h2222});
    wr(8'hB4, 32'h8000F060);
    poll(1'b0, cyc);
    chk("R9 write timeout cycles", cyc, TMO);
    noack = 0;

    chk("R10 fields stable", stab_err, 0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule